// File: doc/BRIEF.md
# Load/Store Effective Address and Byte-Lane Unit

This block sits between the instruction decode and the data cache of a 64-bit load/store pipe. It forms the effective address of a memory access as a base register value plus a sign-extended 16-bit displacement. It then finds which byte lanes of the 64-bit doubleword the access covers, using the access size, the low three address bits and the current byte order.

For stores it moves the right-aligned store operand onto the lanes the access covers and produces the matching byte-enable mask. For loads it takes the raw doubleword read from memory, pulls the addressed field down to bit 0, and widens it to 64 bits with sign or zero fill. An access whose size and low address bits do not form a legal pair is not split and not realigned. Instead the block raises an address-error flag and suppresses every lane.

The results leave through one output register stage by default. A parameter removes that stage, and the unit is then purely combinational.

Top module: `ldst_lane_unit`

## Requirements
- R1: `eff_addr` equals `base_addr` plus `imm_off` sign-extended to the address width, taken modulo 2^AW.
- R2: The size code on `acc_size` selects the field length: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. A legal access has `eff_addr[2:0]` as a multiple of the field length: bytes at any offset, halfwords at even offsets, words at offsets 0 and 4, and doublewords only at offset 0.
- R3: With `big_endian`=0, an access at offset o of n bytes covers lanes o to o+n-1, where lane k is bits [8k+7:8k]. The lowest-addressed byte sits in lane o and holds the least-significant byte of the value.
- R4: With `big_endian`=1, address offset o maps to lane 7-o. An n-byte field covers lanes 8-o-n to 7-o, and the most-significant byte of the value sits at the lowest address.
- R5: An access whose size and offset are not a legal pair under R2 sets `addr_err` to 1. A legal access sets it to 0.
- R6: While `addr_err` is 1, `byte_en`, `st_lanes` and `ld_result` are all zero.
- R7: For a legal access, `byte_en` has a 1 on exactly the covered lanes. `st_lanes` carries byte s of `st_data` in the lane that holds value byte s, and all lanes that are not covered are zero.
- R8: For a legal load, `ld_result` holds the field taken from `ld_raw` with its least-significant byte at bit 0. Accesses shorter than 8 bytes are filled with the field's top bit when `ld_unsigned`=0 and with zeros when `ld_unsigned`=1. A doubleword is returned whole.
- R9: With the default REG_OUT=1, every output reflects the inputs present at the previous rising clock edge and holds until the next edge.
- R10: A synchronous active-high `rst` drives every output to zero at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | AW | Base register value |
| imm_off | input | 16 | Signed displacement from the instruction |
| acc_size | input | 2 | Access size code (0 byte, 1 half, 2 word, 3 double) |
| big_endian | input | 1 | Byte order select, 1 = big-endian |
| ld_unsigned | input | 1 | 1 = zero-extend load data, 0 = sign-extend |
| st_data | input | 64 | Store operand, right-aligned |
| ld_raw | input | 64 | Doubleword read from memory |
| eff_addr | output | AW | Effective address |
| byte_en | output | 8 | Byte-lane enable mask |
| st_lanes | output | 64 | Store data steered onto its lanes |
| ld_result | output | 64 | Extracted and extended load value |
| addr_err | output | 1 | Address-error exception flag |

## Verification
A wrong lane base in the decode shows up as a shifted or mirrored `byte_en` pattern. It also shows as store bytes in the wrong lanes and a load field read from the wrong bytes, all one clock after the access is presented. A wrong alignment test shows up in the same cycle as either a spurious `addr_err` with zeroed lanes, or a missing `addr_err` together with a mask of the wrong width. Errors in extension or byte ordering only show in `ld_result` and `st_lanes`. For that reason the cases use values with the top bit set and asymmetric byte patterns, so that a swapped byte or a wrong fill bit cannot match the expected value by chance.

// File: rtl/ldst_lane_pkg.sv
package ldst_lane_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // Number of bytes covered by a size code.
  function automatic int size_to_bytes(acc_size_e s);
    return 1 << int'(s);
  endfunction

endpackage

// File: rtl/ldst_ea_adder.sv
module ldst_ea_adder #(
  parameter int AW   = 32,
  parameter int IMMW = 16
) (
  input  logic [AW-1:0]   base_addr,
  input  logic [IMMW-1:0] imm_off,
  output logic [AW-1:0]   eff_addr
);

  localparam int EXTW = AW - IMMW;

  logic [AW-1:0] imm_sext;

  generate
    if (EXTW > 0) begin : g_ext
      assign imm_sext = {{EXTW{imm_off[IMMW-1]}}, imm_off};
    end else begin : g_trunc
      assign imm_sext = imm_off[AW-1:0];
    end
  endgenerate

  assign eff_addr = base_addr + imm_sext;

endmodule

// File: rtl/ldst_lane_map.sv
module ldst_lane_map
  import ldst_lane_pkg::*;
#(
  parameter int LANES = 8,
  parameter int OFFW  = $clog2(LANES)
) (
  input  acc_size_e        size,
  input  logic [OFFW-1:0]  offset,
  input  logic             big_endian,
  output logic [LANES-1:0] mask,
  output logic [OFFW-1:0]  low_lane,
  output logic             misaligned
);

  logic [OFFW:0] nbytes;
  logic [OFFW:0] align_bits;
  int            low_int;

  assign nbytes     = (OFFW+1)'(size_to_bytes(size));
  assign align_bits = nbytes - (OFFW+1)'(1);
  assign misaligned = |(offset & align_bits[OFFW-1:0]);

  // Lowest lane of the field; big-endian mirrors the offset within the doubleword.
  always_comb begin
    if (big_endian) low_int = LANES - int'(offset) - int'(nbytes);
    else            low_int = int'(offset);
  end

  assign low_lane = OFFW'(low_int);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign mask[i] = !misaligned && (i >= int'(low_lane)) &&
                       (i < int'(low_lane) + int'(nbytes));
    end
  endgenerate

endmodule

// File: rtl/ldst_store_steer.sv
module ldst_store_steer #(
  parameter int LANES = 8,
  parameter int BW    = 8,
  parameter int OFFW  = $clog2(LANES)
) (
  input  logic [LANES*BW-1:0] st_data,
  input  logic [OFFW-1:0]     low_lane,
  input  logic [LANES-1:0]    mask,
  output logic [LANES*BW-1:0] st_lanes
);

  localparam int DW = LANES * BW;

  logic [DW-1:0] shifted;

  assign shifted = st_data << (int'(low_lane) * BW);

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign st_lanes[i*BW +: BW] = mask[i] ? shifted[i*BW +: BW] : '0;
    end
  endgenerate

endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
  import ldst_lane_pkg::*;
#(
  parameter int LANES = 8,
  parameter int BW    = 8,
  parameter int OFFW  = $clog2(LANES)
) (
  input  logic [LANES*BW-1:0] ld_raw,
  input  logic [OFFW-1:0]     low_lane,
  input  acc_size_e           size,
  input  logic                ld_unsigned,
  input  logic                kill,
  output logic [LANES*BW-1:0] ld_result
);

  localparam int DW = LANES * BW;

  logic [DW-1:0] shifted;
  int            nbits;
  logic          fill;

  assign shifted = ld_raw >> (int'(low_lane) * BW);
  assign nbits   = size_to_bytes(size) * BW;
  assign fill    = ld_unsigned ? 1'b0 : shifted[nbits-1];

  always_comb begin
    ld_result = '0;
    if (!kill) begin
      for (int j = 0; j < DW; j++) begin
        ld_result[j] = (j < nbits) ? shifted[j] : fill;
      end
    end
  end

endmodule

// File: rtl/ldst_lane_unit.sv
module ldst_lane_unit
  import ldst_lane_pkg::*;
#(
  parameter int AW      = 32,
  parameter int IMMW    = 16,
  parameter int LANES   = 8,
  parameter int BW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       base_addr,
  input  logic [IMMW-1:0]     imm_off,
  input  logic [1:0]          acc_size,
  input  logic                big_endian,
  input  logic                ld_unsigned,
  input  logic [LANES*BW-1:0] st_data,
  input  logic [LANES*BW-1:0] ld_raw,
  output logic [AW-1:0]       eff_addr,
  output logic [LANES-1:0]    byte_en,
  output logic [LANES*BW-1:0] st_lanes,
  output logic [LANES*BW-1:0] ld_result,
  output logic                addr_err
);

  localparam int DW   = LANES * BW;
  localparam int OFFW = $clog2(LANES);

  acc_size_e       size_c;
  logic [AW-1:0]   ea_c;
  logic [LANES-1:0] mask_c;
  logic [OFFW-1:0] low_c;
  logic            err_c;
  logic [DW-1:0]   st_c;
  logic [DW-1:0]   ld_c;

  assign size_c = acc_size_e'(acc_size);

  ldst_ea_adder #(.AW(AW), .IMMW(IMMW)) u_ea (
    .base_addr (base_addr),
    .imm_off   (imm_off),
    .eff_addr  (ea_c)
  );

  ldst_lane_map #(.LANES(LANES), .OFFW(OFFW)) u_map (
    .size       (size_c),
    .offset     (ea_c[OFFW-1:0]),
    .big_endian (big_endian),
    .mask       (mask_c),
    .low_lane   (low_c),
    .misaligned (err_c)
  );

  ldst_store_steer #(.LANES(LANES), .BW(BW), .OFFW(OFFW)) u_st (
    .st_data  (st_data),
    .low_lane (low_c),
    .mask     (mask_c),
    .st_lanes (st_c)
  );

  ldst_load_extract #(.LANES(LANES), .BW(BW), .OFFW(OFFW)) u_ld (
    .ld_raw      (ld_raw),
    .low_lane    (low_c),
    .size        (size_c),
    .ld_unsigned (ld_unsigned),
    .kill        (err_c),
    .ld_result   (ld_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [AW-1:0]    ea_q;
      logic [LANES-1:0] en_q;
      logic [DW-1:0]    st_q;
      logic [DW-1:0]    ld_q;
      logic             err_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          ea_q  <= '0;
          en_q  <= '0;
          st_q  <= '0;
          ld_q  <= '0;
          err_q <= 1'b0;
        end else begin
          ea_q  <= ea_c;
          en_q  <= mask_c;
          st_q  <= st_c;
          ld_q  <= ld_c;
          err_q <= err_c;
        end
      end

      assign eff_addr  = ea_q;
      assign byte_en   = en_q;
      assign st_lanes  = st_q;
      assign ld_result = ld_q;
      assign addr_err  = err_q;
    end else begin : g_comb
      assign eff_addr  = ea_c;
      assign byte_en   = mask_c;
      assign st_lanes  = st_c;
      assign ld_result = ld_c;
      assign addr_err  = err_c;
    end
  endgenerate

endmodule

// File: rtl/ldst_lane_unit_chk.sv
module ldst_lane_unit_chk #(
  parameter int AW      = 32,
  parameter int IMMW    = 16,
  parameter int LANES   = 8,
  parameter int BW      = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic [AW-1:0]       base_addr,
  input logic [IMMW-1:0]     imm_off,
  input logic [1:0]          acc_size,
  input logic                big_endian,
  input logic                ld_unsigned,
  input logic [LANES*BW-1:0] st_data,
  input logic [LANES*BW-1:0] ld_raw,
  input logic [AW-1:0]       eff_addr,
  input logic [LANES-1:0]    byte_en,
  input logic [LANES*BW-1:0] st_lanes,
  input logic [LANES*BW-1:0] ld_result,
  input logic                addr_err
);

  localparam int DW = LANES * BW;

  logic [AW-1:0]   base_r;
  logic [IMMW-1:0] imm_r;
  logic [1:0]      size_r;
  logic            uns_r;
  logic            live;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        base_r <= base_addr;
        imm_r  <= imm_off;
        size_r <= acc_size;
        uns_r  <= ld_unsigned;
        live   <= !rst;
      end

      // R10: reset clears the registered outputs
      assert_reset_clear_R10: assert property (@(posedge clk)
        rst |=> (byte_en == '0 && !addr_err && st_lanes == '0 && ld_result == '0));
    end else begin : g_comb
      assign base_r = base_addr;
      assign imm_r  = imm_off;
      assign size_r = acc_size;
      assign uns_r  = ld_unsigned;
      assign live   = 1'b1;
    end
  endgenerate

  function automatic logic [DW-1:0] lane_bits(logic [LANES-1:0] en);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < LANES; i++) r[i*BW +: BW] = {BW{en[i]}};
    return r;
  endfunction

  assert_ea_sum_R1: assert property (@(posedge clk) disable iff (rst)
    live |-> eff_addr == base_r + AW'({{(AW-IMMW){imm_r[IMMW-1]}}, imm_r}));

  assert_err_alignment_R5: assert property (@(posedge clk) disable iff (rst)
    live |-> addr_err == ((int'(eff_addr[2:0]) % (1 << int'(size_r))) != 0));

  assert_err_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    addr_err |-> (byte_en == '0 && st_lanes == '0 && ld_result == '0));

  assert_lane_count_R2: assert property (@(posedge clk) disable iff (rst)
    (live && !addr_err) |-> $countones(byte_en) == (1 << int'(size_r)));

  assert_store_in_lanes_R7: assert property (@(posedge clk) disable iff (rst)
    (st_lanes & ~lane_bits(byte_en)) == '0);

  assert_byte_sext_R8: assert property (@(posedge clk) disable iff (rst)
    (live && !addr_err && size_r == 2'd0 && !uns_r) |->
      ld_result[DW-1:BW] == {(DW-BW){ld_result[BW-1]}});

endmodule

bind ldst_lane_unit ldst_lane_unit_chk #(
  .AW(AW), .IMMW(IMMW), .LANES(LANES), .BW(BW), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/ldst_lane_unit_test.sv
`timescale 1ns/1ps
module ldst_lane_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] base_addr = '0;
  logic [15:0] imm_off = '0;
  logic [1:0]  acc_size = '0;
  logic        big_endian = 1'b0;
  logic        ld_unsigned = 1'b0;
  logic [63:0] st_data = '0;
  logic [63:0] ld_raw = '0;
  logic [31:0] eff_addr;
  logic [7:0]  byte_en;
  logic [63:0] st_lanes;
  logic [63:0] ld_result;
  logic        addr_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  ldst_lane_unit uut (
    .clk(clk), .rst(rst), .base_addr(base_addr), .imm_off(imm_off),
    .acc_size(acc_size), .big_endian(big_endian), .ld_unsigned(ld_unsigned),
    .st_data(st_data), .ld_raw(ld_raw), .eff_addr(eff_addr), .byte_en(byte_en),
    .st_lanes(st_lanes), .ld_result(ld_result), .addr_err(addr_err)
  );

  // Expected results built byte by byte from the requirement text.
  typedef struct packed {
    logic [31:0] ea;
    logic [7:0]  en;
    logic [63:0] st;
    logic [63:0] ld;
    logic        err;
  } exp_t;

  function automatic exp_t model(logic [31:0] b, logic [15:0] im, logic [1:0] sz,
                                 logic be, logic uns, logic [63:0] sd, logic [63:0] raw);
    exp_t e;
    int o, n, lane, sig;
    logic [63:0] v;
    e = '0;
    v = '0;
    e.ea = b + {{16{im[15]}}, im};
    o = int'(e.ea[2:0]);
    n = 1 << int'(sz);
    e.err = (o % n) != 0;
    if (!e.err) begin
      for (int k = 0; k < n; k++) begin
        lane = be ? 7 - (o + k) : o + k;
        sig  = be ? n - 1 - k : k;
        e.en[lane] = 1'b1;
        e.st[lane*8 +: 8] = sd[sig*8 +: 8];
        v[sig*8 +: 8] = raw[lane*8 +: 8];
      end
      if (n < 8 && !uns && v[n*8-1]) v = v | ~((64'd1 << (n*8)) - 64'd1);
      e.ld = v;
    end
    return e;
  endfunction

  task automatic compare(string req, exp_t e);
    tests++;
    if (eff_addr !== e.ea || byte_en !== e.en || st_lanes !== e.st ||
        ld_result !== e.ld || addr_err !== e.err) begin
      fails++;
      $display("FAIL %s: got ea=%h en=%b st=%h ld=%h err=%b exp ea=%h en=%b st=%h ld=%h err=%b",
               req, eff_addr, byte_en, st_lanes, ld_result, addr_err,
               e.ea, e.en, e.st, e.ld, e.err);
    end
  endtask

  // Drive at a falling edge, check one rising edge later at the next falling edge.
  task automatic run(string req, logic [31:0] b, logic [15:0] im, logic [1:0] sz,
                     logic be, logic uns, logic [63:0] sd, logic [63:0] raw);
    @(negedge clk);
    base_addr = b; imm_off = im; acc_size = sz; big_endian = be;
    ld_unsigned = uns; st_data = sd; ld_raw = raw;
    @(negedge clk);
    compare(req, model(b, im, sz, be, uns, sd, raw));
  endtask

  localparam logic [63:0] SD  = 64'h8899_AABB_CCDD_EEF1;
  localparam logic [63:0] RAW = 64'hF7E6_D5C4_B3A2_9180;

  task automatic t_reset();
    exp_t z;
    z = '0;
    @(negedge clk);
    rst = 1'b1;
    base_addr = 32'h1234_5679; acc_size = 2'd1; st_data = SD; ld_raw = RAW;
    @(negedge clk);
    compare("R10 reset clears outputs", z);
    rst = 1'b0;
  endtask

  task automatic t_byte_le();
    for (int o = 0; o < 8; o++)
      run("R3 byte little-endian", 32'h0000_1000, 16'(o), 2'd0, 1'b0, 1'b1, SD, RAW);
  endtask

  task automatic t_byte_be();
    for (int o = 0; o < 8; o++)
      run("R4 byte big-endian", 32'h0000_2000, 16'(o), 2'd0, 1'b1, 1'b0, SD, RAW);
  endtask

  task automatic t_half_word();
    for (int o = 0; o < 8; o += 2) begin
      run("R3 R7 halfword LE", 32'h100, 16'(o), 2'd1, 1'b0, 1'b0, SD, RAW);
      run("R4 R7 halfword BE", 32'h100, 16'(o), 2'd1, 1'b1, 1'b1, SD, RAW);
    end
    run("R3 word LE offset 0", 32'h200, 16'd0, 2'd2, 1'b0, 1'b0, SD, RAW);
    run("R3 word LE offset 4", 32'h200, 16'd4, 2'd2, 1'b0, 1'b1, SD, RAW);
    run("R4 word BE offset 0", 32'h200, 16'd0, 2'd2, 1'b1, 1'b0, SD, RAW);
    run("R4 word BE offset 4", 32'h200, 16'd4, 2'd2, 1'b1, 1'b0, SD, RAW);
  endtask

  task automatic t_dword();
    run("R8 doubleword LE", 32'h300, 16'd8, 2'd3, 1'b0, 1'b0, SD, RAW);
    run("R8 doubleword BE", 32'h300, 16'd0, 2'd3, 1'b1, 1'b1, SD, RAW);
  endtask

  task automatic t_misaligned();
    run("R5 R6 half odd", 32'h400, 16'd3, 2'd1, 1'b0, 1'b0, SD, RAW);
    run("R5 R6 word at 2", 32'h400, 16'd2, 2'd2, 1'b1, 1'b0, SD, RAW);
    run("R5 R6 word at 6", 32'h400, 16'd6, 2'd2, 1'b0, 1'b1, SD, RAW);
    run("R5 R6 dword at 4", 32'h400, 16'd4, 2'd3, 1'b0, 1'b0, SD, RAW);
    run("R2 dword at 1", 32'h400, 16'd1, 2'd3, 1'b1, 1'b0, SD, RAW);
  endtask

  task automatic t_extension();
    logic [63:0] r;
    r = 64'h0000_0000_8000_7F80;
    run("R8 byte sign fill", 32'h0, 16'd0, 2'd0, 1'b0, 1'b0, SD, r);
    run("R8 byte zero fill", 32'h0, 16'd0, 2'd0, 1'b0, 1'b1, SD, r);
    run("R8 half positive", 32'h0, 16'd0, 2'd1, 1'b0, 1'b0, SD, r);
    run("R8 word sign fill", 32'h0, 16'd0, 2'd2, 1'b0, 1'b0, SD, r);
    run("R8 word zero fill", 32'h0, 16'd0, 2'd2, 1'b0, 1'b1, SD, r);
  endtask

  task automatic t_address();
    run("R1 negative displacement", 32'h0000_1006, 16'hFFFE, 2'd2, 1'b0, 1'b0, SD, RAW);
    run("R1 wrap past top", 32'hFFFF_FFFC, 16'h0006, 2'd1, 1'b0, 1'b0, SD, RAW);
    run("R1 wrap below zero", 32'h0000_0002, 16'h8000, 2'd1, 1'b1, 1'b0, SD, RAW);
  endtask

  task automatic t_latency();
    exp_t a;
    a = model(32'h500, 16'd1, 2'd0, 1'b0, 1'b0, SD, RAW);
    run("R9 first access", 32'h500, 16'd1, 2'd0, 1'b0, 1'b0, SD, RAW);
    base_addr = 32'h600; imm_off = 16'd3; acc_size = 2'd1;
    #1;
    compare("R9 outputs hold before edge", a);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_byte_le();
    t_byte_be();
    t_half_word();
    t_dword();
    t_misaligned();
    t_extension();
    t_address();
    t_latency();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule